// File: doc/BRIEF.md
# Shared Pin Function And Event Router

This block controls a bank of pads. Each pad is either an LCD segment output or a general-purpose I/O. A per-pin mode bit chooses between the two. In GPIO mode, per-pin direction and data registers set what the pad does. The lowest group of pads comes out of reset as outputs. A single port-enable bit gates those pads off until software sets it, so the pads stay quiet while the chip starts up.

Some GPIO pads, and one dedicated push-button input, can be connected to internal resources such as an interrupt request or a timer control. Each of these sources has a 3-bit selector that names one of seven resource lines. Every source that selects the same line is OR-merged onto it. The block takes the pad level after a two-flop synchronizer. A pad that is driven as an output can therefore still raise its resource. Software programs everything through one register write port that carries a kind code, a pin index and a value.

Top module: `pin_mux_router`

## Requirements
- R1: While a pin's mode bit is 1 (segment mode), `seg_drv` for that pin is 1, `pin_oe` is 0 and `pin_out` follows `seg_data`.
- R2: While a pin's mode bit is 0, `seg_drv` is 0 and `pin_out` shows the written data bit. For pins at index NUM_LOW and above, `pin_oe` equals the direction bit (1 = output).
- R3: After reset, every pin is in GPIO mode with data 0, and `res_out` is 0. Pins below NUM_LOW (16) have direction set to output. All other pins are inputs. The port-enable bit is 0 and every `pin_oe` is 0.
- R4: While the port-enable bit is 0, `pin_oe` is 0 for every pin below NUM_LOW. Once it is set, those pins drive according to their direction bit.
- R5: A selector value of 0 routes the pin to no line. A value k from 1 to 7 routes the pin to `res_out[k-1]`. The routable pins are indexes ROUTE_LO (2) to ROUTE_HI (11).
- R6: A resource line is the OR of the synchronized levels of all sources that select it.
- R7: The push-button input has its own selector, with the same coding as the pin selectors, and is never a segment pin.
- R8: Routing uses the pad input level, whatever the pin's direction. A pin that is configured as an output still drives its resource line.
- R9: A change on `pin_in` or `btn_in` reaches `res_out` after the second rising clock edge, and not after the first.
- R10: Pins outside ROUTE_LO..ROUTE_HI never drive a resource line. A route write to such an index has no effect. A routable pin in segment mode contributes nothing.
- R11: When `cfg_we` is 1, a rising edge applies `cfg_val` according to `cfg_kind`. The codes are: 0 = mode bit, 1 = direction, 2 = data, 3 = pin selector, 4 = button selector, 5 = port enable. Codes 0, 1, 2 and 5 use `cfg_val[0]`, and codes 0 to 3 address `cfg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 3 | Register kind code |
| cfg_idx | input | IDX_W (5) | Pin index for per-pin kinds |
| cfg_val | input | 3 | Write value |
| seg_data | input | NUM_PINS (24) | Segment data for each pin |
| pin_in | input | NUM_PINS (24) | Pad input levels |
| btn_in | input | 1 | Push-button input |
| pin_out | output | NUM_PINS (24) | Pad output value |
| pin_oe | output | NUM_PINS (24) | GPIO output enable per pad |
| seg_drv | output | NUM_PINS (24) | Segment mode indicator per pad |
| res_out | output | 7 | Resource lines |

## Verification
The bench first sets up a fixed routing: two pins share line 1, a pin and the button share line 2, one pin uses line 7, one pin uses line 3, and one pin has selector 0. It then applies pad patterns from a table. Single-pin patterns confirm that each selector code reaches the right line. Paired patterns show whether sources are OR-merged or override one another. The zero-selector pin and the pins outside the routable range are tried in case they leak onto a line. An all-ones pattern checks the merge across every line at once. All routed pins in the table are outputs when they are tried, so the table also separates pad-level sampling from direction-based masking. Directed tests then cover the two-edge latency, the port-enable gate, segment-mode masking and ignored out-of-range route writes.

// File: rtl/pin_router_pkg.sv
package pin_router_pkg;
  localparam int SEL_W   = 3;
  localparam int NUM_RES = (1 << SEL_W) - 1;

  typedef enum logic [2:0] {
    CFG_MAP   = 3'd0,
    CFG_DIR   = 3'd1,
    CFG_DOUT  = 3'd2,
    CFG_ROUTE = 3'd3,
    CFG_BTN   = 3'd4,
    CFG_PEN   = 3'd5
  } cfg_kind_e;

  // true when selector code picks resource line 'line' (0-based)
  function automatic logic sel_hits(input logic [SEL_W-1:0] sel, input int line);
    return (sel != '0) && (int'(sel) == line + 1);
  endfunction

  // direction after reset: low pins start as outputs
  function automatic logic dir_at_reset(input int pin, input int n_low);
    return pin < n_low;
  endfunction
endpackage

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pin_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int NUM_LOW  = 16,
  parameter int ROUTE_LO = 2,
  parameter int ROUTE_HI = 11,
  localparam int IDX_W     = $clog2(NUM_PINS),
  localparam int NUM_ROUTE = ROUTE_HI - ROUTE_LO + 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [2:0]                          kind,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [SEL_W-1:0]                    val,
  output logic [NUM_PINS-1:0]                 map_q,
  output logic [NUM_PINS-1:0]                 dir_q,
  output logic [NUM_PINS-1:0]                 dout_q,
  output logic [NUM_ROUTE-1:0][SEL_W-1:0]     route_q,
  output logic [SEL_W-1:0]                    btn_sel_q,
  output logic                                port_en_q
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam logic DIR_RST = dir_at_reset(g, NUM_LOW);
    wire hit = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[g]  <= 1'b0;
        dir_q[g]  <= DIR_RST;
        dout_q[g] <= 1'b0;
      end else if (hit) begin
        if (kind == CFG_MAP)  map_q[g]  <= val[0];
        if (kind == CFG_DIR)  dir_q[g]  <= val[0];
        if (kind == CFG_DOUT) dout_q[g] <= val[0];
      end
    end
  end

  for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_route
    wire hit = we && (kind == CFG_ROUTE) && (idx == IDX_W'(ROUTE_LO + r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   route_q[r] <= '0;
      else if (hit) route_q[r] <= val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_sel_q <= '0;
      port_en_q <= 1'b0;
    end else if (we) begin
      if (kind == CFG_BTN) btn_sel_q <= val;
      if (kind == CFG_PEN) port_en_q <= val[0];
    end
  end
endmodule

// File: rtl/pin_pad_ctrl.sv
module pin_pad_ctrl #(
  parameter int NUM_PINS = 24,
  parameter int NUM_LOW  = 16
) (
  input  logic [NUM_PINS-1:0] map_q,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] dout_q,
  input  logic [NUM_PINS-1:0] seg_data,
  input  logic                port_en,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] seg_drv
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pad
    logic gate;
    if (g < NUM_LOW) begin : g_gated
      assign gate = port_en;
    end else begin : g_free
      assign gate = 1'b1;
    end
    assign seg_drv[g] = map_q[g];
    assign pin_out[g] = map_q[g] ? seg_data[g] : dout_q[g];
    assign pin_oe[g]  = ~map_q[g] & dir_q[g] & gate;
  end
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/event_router.sv
module event_router
  import pin_router_pkg::*;
#(
  parameter int NUM_ROUTE = 10
) (
  input  logic [NUM_ROUTE-1:0]            live,
  input  logic [NUM_ROUTE-1:0][SEL_W-1:0] route_sel,
  input  logic                            btn_lvl,
  input  logic [SEL_W-1:0]                btn_sel,
  output logic [NUM_RES-1:0]              res
);
  for (genvar k = 0; k < NUM_RES; k++) begin : g_line
    logic acc;
    always_comb begin
      acc = btn_lvl & sel_hits(btn_sel, k);
      for (int p = 0; p < NUM_ROUTE; p++) begin
        acc = acc | (live[p] & sel_hits(route_sel[p], k));
      end
    end
    assign res[k] = acc;
  end
endmodule

// File: rtl/pin_mux_router.sv
module pin_mux_router
  import pin_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int NUM_LOW  = 16,
  parameter int ROUTE_LO = 2,
  parameter int ROUTE_HI = 11,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_kind,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [SEL_W-1:0]    cfg_val,
  input  logic [NUM_PINS-1:0] seg_data,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                btn_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] seg_drv,
  output logic [NUM_RES-1:0]  res_out
);
  localparam int NUM_ROUTE = ROUTE_HI - ROUTE_LO + 1;

  logic [NUM_PINS-1:0]             map_q, dir_q, dout_q;
  logic [NUM_ROUTE-1:0][SEL_W-1:0] route_q;
  logic [SEL_W-1:0]                btn_sel_q;
  logic                            port_en_q;
  logic [NUM_PINS-1:0]             pin_sync_q;
  logic                            btn_sync_q;
  logic [NUM_ROUTE-1:0]            route_live;   // synced level of routable GPIO pins

  pin_cfg_regs #(
    .NUM_PINS(NUM_PINS), .NUM_LOW(NUM_LOW), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx), .val(cfg_val),
    .map_q(map_q), .dir_q(dir_q), .dout_q(dout_q), .route_q(route_q),
    .btn_sel_q(btn_sel_q), .port_en_q(port_en_q)
  );

  pin_pad_ctrl #(.NUM_PINS(NUM_PINS), .NUM_LOW(NUM_LOW)) u_pad (
    .map_q(map_q), .dir_q(dir_q), .dout_q(dout_q), .seg_data(seg_data),
    .port_en(port_en_q), .pin_out(pin_out), .pin_oe(pin_oe), .seg_drv(seg_drv)
  );

  pin_sync #(.W(NUM_PINS + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({btn_in, pin_in}), .q({btn_sync_q, pin_sync_q})
  );

  for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_live
    assign route_live[r] = pin_sync_q[ROUTE_LO + r] & ~map_q[ROUTE_LO + r];
  end

  event_router #(.NUM_ROUTE(NUM_ROUTE)) u_route (
    .live(route_live), .route_sel(route_q), .btn_lvl(btn_sync_q),
    .btn_sel(btn_sel_q), .res(res_out)
  );
endmodule

// File: rtl/pin_mux_router_chk.sv
module pin_mux_router_chk
  import pin_router_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int NUM_LOW   = 16,
  parameter int NUM_ROUTE = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] seg_drv,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] seg_data,
  input logic                port_en_q,
  input logic [NUM_ROUTE-1:0] route_live,
  input logic                btn_sync_q,
  input logic [SEL_W-1:0]    btn_sel_q,
  input logic [NUM_RES-1:0]  res_out
);
  assert_seg_no_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_drv & pin_oe) == '0);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_seg
    assert_seg_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
      seg_drv[g] |-> (pin_out[g] == seg_data[g]));
  end

  assert_low_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_q |-> (pin_oe[NUM_LOW-1:0] == '0));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_live == '0 && !btn_sync_q) |-> (res_out == '0));

  assert_btn_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_sel_q != '0 && btn_sync_q) |-> res_out[btn_sel_q - 3'd1]);
endmodule

bind pin_mux_router pin_mux_router_chk #(
  .NUM_PINS(NUM_PINS), .NUM_LOW(NUM_LOW), .NUM_ROUTE(ROUTE_HI - ROUTE_LO + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_drv(seg_drv), .pin_oe(pin_oe), .pin_out(pin_out),
  .seg_data(seg_data), .port_en_q(port_en_q), .route_live(route_live),
  .btn_sync_q(btn_sync_q), .btn_sel_q(btn_sel_q), .res_out(res_out)
);

// File: tb/pin_mux_router_tb.sv
`timescale 1ns/1ps
module pin_mux_router_tb;
  import pin_router_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_kind = '0;
  logic [4:0]  cfg_idx = '0;
  logic [2:0]  cfg_val = '0;
  logic [23:0] seg_data = '0;
  logic [23:0] pin_in = '0;
  logic        btn_in = 1'b0;
  logic [23:0] pin_out, pin_oe, seg_drv;
  logic [6:0]  res_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pin_mux_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_val(cfg_val), .seg_data(seg_data), .pin_in(pin_in), .btn_in(btn_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .seg_drv(seg_drv), .res_out(res_out)
  );

  // {expected res_out, btn_in, pin_in}; routing: p2,p3->1 p4,btn->2 p11->3 p5->7 p6->0
  localparam logic [31:0] VEC [11] = '{
    {7'h00, 1'b0, 24'h000000},
    {7'h01, 1'b0, 24'h000004},
    {7'h01, 1'b0, 24'h000008},
    {7'h01, 1'b0, 24'h00000C},
    {7'h02, 1'b0, 24'h000010},
    {7'h02, 1'b1, 24'h000000},
    {7'h40, 1'b0, 24'h000020},
    {7'h00, 1'b0, 24'h000040},
    {7'h04, 1'b0, 24'h000800},
    {7'h00, 1'b0, 24'hFFF003},
    {7'h47, 1'b1, 24'hFFFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] kind, input int idx, input logic [2:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = 5'(idx); cfg_val = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle(input int edges);
    repeat (edges) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 oe", 32'(pin_oe), 0);
    chk("R3 seg_drv", 32'(seg_drv), 0);
    chk("R3 res", 32'(res_out), 0);
    chk("R3 out", 32'(pin_out), 0);

    // R4 port enable gate, R3 reset directions, R11 kind 5
    wr(CFG_PEN, 0, 3'd1);
    chk("R4 low oe released", 32'(pin_oe), 32'h00FFFF);
    chk("R3 high pins input", 32'(pin_oe[23:16]), 0);
    wr(CFG_PEN, 0, 3'd0);
    chk("R4 low oe gated", 32'(pin_oe), 0);
    wr(CFG_PEN, 0, 3'd1);

    // routing setup, R11 kinds 3 and 4
    wr(CFG_ROUTE, 2, 3'd1);
    wr(CFG_ROUTE, 3, 3'd1);
    wr(CFG_ROUTE, 4, 3'd2);
    wr(CFG_ROUTE, 5, 3'd7);
    wr(CFG_ROUTE, 6, 3'd0);
    wr(CFG_ROUTE, 11, 3'd3);
    wr(CFG_BTN, 0, 3'd2);

    // table: R5 codes, R6 OR merge, R7 button, R8 outputs still route, R10 outside range
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      pin_in = VEC[i][23:0];
      btn_in = VEC[i][24];
      settle(2);
      chk($sformatf("R5/R6/R7/R8/R10 vector %0d", i), 32'(res_out), 32'(VEC[i][31:25]));
    end
    chk("R8 routed pins were outputs", 32'(pin_oe[5:2]), 32'hF);

    // R9 two-edge latency
    @(negedge clk);
    pin_in = '0; btn_in = 1'b0;
    settle(2);
    pin_in[2] = 1'b1;
    settle(1);
    chk("R9 after one edge", 32'(res_out), 0);
    settle(1);
    chk("R9 after two edges", 32'(res_out), 32'h01);

    // R10 out-of-range route write ignored
    pin_in = '0;
    wr(CFG_ROUTE, 12, 3'd4);
    pin_in[12] = 1'b1;
    settle(2);
    chk("R10 pin12 route write ignored", 32'(res_out), 0);

    // R10 segment-mode routable pin contributes nothing
    pin_in = '0;
    wr(CFG_MAP, 3, 3'd1);
    pin_in[3] = 1'b1;
    settle(2);
    chk("R10 segment pin masked", 32'(res_out), 0);
    wr(CFG_MAP, 3, 3'd0);
    chk("R10 pin3 back to GPIO", 32'(res_out), 32'h01);
    pin_in = '0;

    // R1 segment mode, R11 kind 0
    seg_data[20] = 1'b1;
    wr(CFG_DIR, 20, 3'd1);
    wr(CFG_MAP, 20, 3'd1);
    chk("R1 seg_drv", 32'(seg_drv[20]), 1);
    chk("R1 oe off", 32'(pin_oe[20]), 0);
    chk("R1 out follows seg", 32'(pin_out[20]), 1);
    seg_data[20] = 1'b0;
    #1;
    chk("R1 out follows seg low", 32'(pin_out[20]), 0);

    // R2 GPIO mode, R11 kinds 1 and 2
    wr(CFG_MAP, 20, 3'd0);
    wr(CFG_DOUT, 20, 3'd1);
    chk("R2 seg_drv off", 32'(seg_drv[20]), 0);
    chk("R2 oe from dir", 32'(pin_oe[20]), 1);
    chk("R2 out from data", 32'(pin_out[20]), 1);
    wr(CFG_DIR, 20, 3'd0);
    chk("R2 input dir", 32'(pin_oe[20]), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule